// File: doc/BRIEF.md
# Turbo Decoder Iteration Count Predictor

This block sets the operating point of an iterative turbo decoder one code block ahead. When a code block finishes, the decoder reports how many iterations it actually ran. Alongside that count it presents a throughput word, which gives the clock needed per iteration in MHz. From this the block updates a running average of the iteration count and an accumulated prediction error. It then forms a predicted iteration count for the next block. The prediction, scaled by the throughput word, becomes a frequency code in 2 MHz steps. The frequency code is mapped to a 4-bit supply-voltage index.

Iteration quantities are held in fixed point with two fractional bits, so one unit is a quarter iteration. The predictor has two modes. A small accumulated error gives a fine correction around the average. A large accumulated error gives a coarse correction applied to the previous prediction. A one-cycle flag tells the clock and supply controllers when the frequency code or the voltage index has moved. Those controllers sit outside this block.

Top module: `tdp_top`

## Requirements
- R1: After reset the outputs are as follows: the prediction is 20 (5.00 iterations), the frequency code is 135, the voltage index is 15, op_update is 0 and pred_coarse is 0. The internal average starts at 20 and the accumulated error at 0.
- R2: On each completed block the accumulated error gains meas_iter×4 minus the prediction that was in force for that block. The sum saturates to the range −2048..2047 and never wraps.
- R3: On each completed block the average gains floor((meas_iter×4 − average)/8).
- R4: If the magnitude of the updated error is 16 or less, the new prediction is the updated average plus floor(error/32), and pred_coarse reads 0.
- R5: If the magnitude of the updated error exceeds 16, the new prediction is the previous prediction plus floor(error/8), and pred_coarse reads 1.
- R6: The prediction is clamped to 4..32 (1 to 8 iterations) before any later use.
- R7: The frequency code is ceil(prediction×tput_mhz/8), clamped to 12..135. Each code step is 2 MHz, so the range is 24 MHz to 270 MHz.
- R8: The voltage index is ceil((freq_code − 12)×15/123), which is 0 at code 12 and 15 at code 135.
- R9: op_update is high for exactly the one cycle after a blk_done cycle, and only when the frequency code or the voltage index differs from its previous value.
- R10: All outputs change only on the clock edge that samples blk_done high. While blk_done is low they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_done | input | 1 | One-cycle strobe: a code block has completed |
| meas_iter | input | 4 | Iterations used by the completed block |
| tput_mhz | input | 8 | Required MHz per predicted iteration |
| pred_iter | output | 6 | Predicted iterations, in quarter-iteration units |
| pred_coarse | output | 1 | 1 when the last prediction used the coarse correction |
| freq_code | output | 8 | Clock request in 2 MHz steps |
| volt_idx | output | 4 | Supply-voltage index |
| op_update | output | 1 | Operating point changed |

## Verification
The accumulated error is never visible directly. A fault in it, such as wrapping instead of saturating or a wrong sign, first shows as a wrong pred_coarse or pred_iter on the block after the fault. It then spreads into freq_code and volt_idx on that same edge. A saturation fault may stay hidden through a long run of blocks that pin the prediction at its ceiling. It only appears once the measured counts drop and the error starts to come back. The bench therefore keeps a full model of the state and drives long one-sided runs in both directions. A wrong average shows only in fine mode, one block after it is stored.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    typedef enum logic {
        MODE_FINE   = 1'b0,
        MODE_COARSE = 1'b1
    } pmode_e;

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/tdp_err_acc.sv
module tdp_err_acc #(
    parameter int ERRW = 12,
    parameter int PW   = 6
) (
    input  logic signed [ERRW-1:0] acc_i,
    input  logic [PW-1:0]          meas_fx_i,
    input  logic [PW-1:0]          pred_i,
    output logic signed [ERRW-1:0] acc_o
);
    localparam int HI = 2**(ERRW-1) - 1;
    localparam int LO = -(2**(ERRW-1));

    int sum;

    always_comb begin
        sum   = int'(acc_i) + int'(meas_fx_i) - int'(pred_i);
        acc_o = ERRW'(tdp_pkg::clampi(sum, LO, HI));
    end
endmodule

// File: rtl/tdp_freq_quant.sv
module tdp_freq_quant #(
    parameter int PW       = 6,
    parameter int TPW      = 8,
    parameter int FCW      = 8,
    parameter int FB       = 2,
    parameter int FSTEP_SH = 1,
    parameter int FMIN     = 12,
    parameter int FMAX     = 135
) (
    input  logic [PW-1:0]  pred_i,
    input  logic [TPW-1:0] tput_i,
    output logic [FCW-1:0] fcode_o
);
    localparam int SH = FB + FSTEP_SH;

    int req;
    int code;

    always_comb begin
        req     = int'(pred_i) * int'(tput_i);
        code    = (req + (1 << SH) - 1) >>> SH;
        fcode_o = FCW'(tdp_pkg::clampi(code, FMIN, FMAX));
    end
endmodule

// File: rtl/tdp_volt_lut.sv
module tdp_volt_lut #(
    parameter int FCW  = 8,
    parameter int VW   = 4,
    parameter int FMIN = 12,
    parameter int FMAX = 135
) (
    input  logic [FCW-1:0] fcode_i,
    output logic [VW-1:0]  vidx_o
);
    localparam int DEPTH = 1 << FCW;
    localparam int VMAX  = (1 << VW) - 1;
    localparam int SPAN  = FMAX - FMIN;

    function automatic int entry(input int c);
        if (c <= FMIN) return 0;
        if (c >= FMAX) return VMAX;
        return ((c - FMIN) * VMAX + SPAN - 1) / SPAN;
    endfunction

    logic [VW-1:0] tab [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tab
        assign tab[g] = VW'(entry(g));
    end

    assign vidx_o = tab[fcode_i];
endmodule

// File: rtl/tdp_top.sv
module tdp_top #(
    parameter int ITW       = 4,
    parameter int FB        = 2,
    parameter int ITER_MAX  = 8,
    parameter int INIT_IT   = 5,
    parameter int ERRW      = 12,
    parameter int AVG_SH    = 3,
    parameter int THRESH    = 16,
    parameter int FINE_SH   = 5,
    parameter int COARSE_SH = 3,
    parameter int TPW       = 8,
    parameter int FCW       = 8,
    parameter int FSTEP_SH  = 1,
    parameter int FMIN      = 12,
    parameter int FMAX      = 135,
    parameter int VW        = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           blk_done,
    input  logic [ITW-1:0] meas_iter,
    input  logic [TPW-1:0] tput_mhz,
    output logic [ITW+FB-1:0] pred_iter,
    output logic           pred_coarse,
    output logic [FCW-1:0] freq_code,
    output logic [VW-1:0]  volt_idx,
    output logic           op_update
);
    import tdp_pkg::*;

    localparam int PW   = ITW + FB;
    localparam int PMIN = 1 << FB;
    localparam int PMAX = ITER_MAX << FB;
    localparam int PINI = INIT_IT << FB;

    typedef struct packed {
        logic [PW-1:0]          avg;
        logic signed [ERRW-1:0] err;
        logic [PW-1:0]          pred;
        pmode_e                 mode;
        logic [FCW-1:0]         fcode;
        logic [VW-1:0]          vidx;
        logic                   upd;
    } state_t;

    state_t st_q, st_d;

    logic [PW-1:0]          meas_fx;
    logic signed [ERRW-1:0] err_new;
    logic [PW-1:0]          pred_new;
    logic [FCW-1:0]         fcode_new;
    logic [VW-1:0]          vidx_new;
    logic [PW-1:0]          avg_new;
    pmode_e                 mode_new;

    assign meas_fx = {meas_iter, {FB{1'b0}}};

    tdp_err_acc #(.ERRW(ERRW), .PW(PW)) u_err (
        .acc_i(st_q.err), .meas_fx_i(meas_fx), .pred_i(st_q.pred), .acc_o(err_new)
    );

    tdp_freq_quant #(.PW(PW), .TPW(TPW), .FCW(FCW), .FB(FB), .FSTEP_SH(FSTEP_SH),
                     .FMIN(FMIN), .FMAX(FMAX)) u_fq (
        .pred_i(pred_new), .tput_i(tput_mhz), .fcode_o(fcode_new)
    );

    tdp_volt_lut #(.FCW(FCW), .VW(VW), .FMIN(FMIN), .FMAX(FMAX)) u_lut (
        .fcode_i(fcode_new), .vidx_o(vidx_new)
    );

    int a_i;
    int e_i;
    int e_mag;
    int p_i;

    always_comb begin
        a_i      = int'(st_q.avg) + ((int'(meas_fx) - int'(st_q.avg)) >>> AVG_SH);
        avg_new  = PW'(a_i);
        e_i      = int'(err_new);
        e_mag    = (e_i < 0) ? -e_i : e_i;
        if (e_mag <= THRESH) begin
            mode_new = MODE_FINE;
            p_i      = a_i + (e_i >>> FINE_SH);
        end else begin
            mode_new = MODE_COARSE;
            p_i      = int'(st_q.pred) + (e_i >>> COARSE_SH);
        end
        pred_new = PW'(clampi(p_i, PMIN, PMAX));

        st_d     = st_q;
        st_d.upd = 1'b0;
        if (blk_done) begin
            st_d.avg   = avg_new;
            st_d.err   = err_new;
            st_d.pred  = pred_new;
            st_d.mode  = mode_new;
            st_d.fcode = fcode_new;
            st_d.vidx  = vidx_new;
            st_d.upd   = (fcode_new != st_q.fcode) || (vidx_new != st_q.vidx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.avg   <= PW'(PINI);
            st_q.err   <= '0;
            st_q.pred  <= PW'(PINI);
            st_q.mode  <= MODE_FINE;
            st_q.fcode <= FCW'(FMAX);
            st_q.vidx  <= '1;
            st_q.upd   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_iter   = st_q.pred;
    assign pred_coarse = (st_q.mode == MODE_COARSE);
    assign freq_code   = st_q.fcode;
    assign volt_idx    = st_q.vidx;
    assign op_update   = st_q.upd;

    AST_PRED_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pred_iter) >= PMIN) && (int'(pred_iter) <= PMAX)); // R6
    AST_FCODE_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(freq_code) >= FMIN) && (int'(freq_code) <= FMAX)); // R7
    AST_UPD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        op_update |-> $past(blk_done)); // R9
    AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        op_update |-> ((freq_code != $past(freq_code)) || (volt_idx != $past(volt_idx)))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_done |=> ($stable(pred_iter) && $stable(freq_code) && $stable(volt_idx)
                       && $stable(pred_coarse) && !op_update)); // R10
endmodule

// File: tb/sim_tdp_top.sv
`timescale 1ns/1ps
module sim_tdp_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_done = 1'b0;
    logic [3:0] meas_iter = '0;
    logic [7:0] tput_mhz = '0;
    logic [5:0] pred_iter;
    logic       pred_coarse;
    logic [7:0] freq_code;
    logic [3:0] volt_idx;
    logic       op_update;

    int checks = 0;
    int errors = 0;

    int m_avg, m_err, m_pred, m_code, m_vidx, m_coarse, m_upd;

    always #4 clk = ~clk;

    tdp_top u0 (
        .clk(clk), .rst_n(rst_n), .blk_done(blk_done), .meas_iter(meas_iter),
        .tput_mhz(tput_mhz), .pred_iter(pred_iter), .pred_coarse(pred_coarse),
        .freq_code(freq_code), .volt_idx(volt_idx), .op_update(op_update)
    );

    function automatic int clip(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int code_of(input int p, input int t);
        return clip((p * t + 7) >>> 3, 12, 135);
    endfunction

    function automatic int vidx_of(input int c);
        if (c <= 12) return 0;
        return ((c - 12) * 15 + 122) / 123;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model step following R2..R9
    task automatic model(input int meas, input int tput);
        int mf, e, a, p, c, v;
        mf = meas * 4;
        e  = clip(m_err + mf - m_pred, -2048, 2047);
        a  = m_avg + ((mf - m_avg) >>> 3);
        if (((e < 0) ? -e : e) <= 16) begin
            p = a + (e >>> 5); m_coarse = 0;
        end else begin
            p = m_pred + (e >>> 3); m_coarse = 1;
        end
        p = clip(p, 4, 32);
        c = code_of(p, tput);
        v = vidx_of(c);
        m_upd  = ((c != m_code) || (v != m_vidx)) ? 1 : 0;
        m_err  = e; m_avg = a; m_pred = p; m_code = c; m_vidx = v;
    endtask

    task automatic block(input int meas, input int tput);
        @(negedge clk);
        blk_done  = 1'b1;
        meas_iter = 4'(meas);
        tput_mhz  = 8'(tput);
        model(meas, tput);
        @(negedge clk);
        blk_done = 1'b0;
        chk("R2_R3_R6 pred", int'(pred_iter), m_pred);
        chk("R4_R5 mode", int'(pred_coarse), m_coarse);
        chk("R7 freq_code", int'(freq_code), m_code);
        chk("R8 volt_idx", int'(volt_idx), m_vidx);
        chk("R9 update", int'(op_update), m_upd);
        @(negedge clk);
        chk("R9 update drops", int'(op_update), 0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd1234);
        m_avg = 20; m_err = 0; m_pred = 20; m_code = 135; m_vidx = 15; m_coarse = 0; m_upd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pred", int'(pred_iter), 20);
        chk("R1 freq_code", int'(freq_code), 135);
        chk("R1 volt_idx", int'(volt_idx), 15);
        chk("R1 update", int'(op_update), 0);
        chk("R1 mode", int'(pred_coarse), 0);

        // R4 fine mode: measured equals prediction
        block(5, 20);
        // R7 R8 lower clamp: zero throughput
        block(5, 0);
        chk("R7 min code", int'(freq_code), 12);
        chk("R8 min index", int'(volt_idx), 0);
        // R7 R8 upper clamp
        block(5, 255);
        chk("R8 max index", int'(volt_idx), 15);

        // R10 idle hold with inputs wiggling
        @(negedge clk);
        meas_iter = 4'd15; tput_mhz = 8'd3;
        repeat (5) @(negedge clk);
        chk("R10 hold pred", int'(pred_iter), m_pred);
        chk("R10 hold code", int'(freq_code), m_code);
        chk("R10 no update", int'(op_update), 0);

        // R2 R5 R6 saturation run: large counts, then small
        for (int i = 0; i < 90; i++) block(15, 20);
        for (int i = 0; i < 90; i++) block(1, 20);
        for (int i = 0; i < 40; i++) block(4, 33);

        // random blocks
        for (int i = 0; i < 400; i++) begin
            int mm, tt;
            mm = ($urandom % 4 == 0) ? int'($urandom % 16) : 2 + int'($urandom % 6);
            tt = int'($urandom % 256);
            block(mm, tt);
            if ($urandom % 8 == 0) repeat (int'($urandom % 4)) @(negedge clk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule